// File: doc/BRIEF.md
# Overshoot Occurrence Tally

This block sits beside a receiving core and watches one active-low overshoot indicator per bus bit. On every accepted bus transfer it counts how many indicator lines are asserted (driven to 0). It adds that count into a running total that spans a window of transfers.

A window is a fixed number of transfers, set by a parameter. When the window has seen that many valid transfers, the block raises a done flag and stops accumulating. The total register is sized for the worst case, where every line overshoots on every transfer.

The same register is a scan cell chain. While scan is enabled, the total shifts one bit per clock, MSB first, and new counts are ignored. A test controller can therefore read the result out serially, and can also load a value in.

Top module: `ovs_tally`

## Requirements
- R1: After the active-low reset `rst_n`, `total` is 0 and `done` is 0, and a window of WINDOW transfers is open.
- R2: An indicator bit of 0 means an overshoot on that bus bit and 1 means quiet. On each clock with `xfer_vld`=1, `scan_en`=0, `start`=0 and `done`=0, `total` grows by the number of zero bits in `ind_n`. The new value is visible after that clock edge.
- R3: On a clock with `xfer_vld`=0 (and `start`=0, `scan_en`=0), `total` and `done` keep their values.
- R4: `total` is ceil(log2(WINDOW*LINES+1)) bits wide. A window in which every line reads 0 on every transfer ends with `total` = WINDOW*LINES, without wrapping.
- R5: `done` rises after the clock edge that accepts the WINDOW-th valid transfer of a window. Once `done` is 1, further transfers leave `total` unchanged and `done` stays 1 until `start`.
- R6: `start`=1 clears `total` to 0 and `done` to 0 at the next edge and opens a new window. It takes priority over `scan_en` and `xfer_vld`.
- R7: While `scan_en`=1 (and `start`=0), each clock shifts `total` one place toward the MSB and loads `scan_in` into bit 0. `scan_out` always shows the MSB of `total`. Indicator counts are ignored, and the shift does not advance the window's transfer count.
- R8: AW consecutive shifts move the whole register out on `scan_out`, MSB first, and replace it with the AW bits presented on `scan_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ind_n | input | LINES | Overshoot indicators, 0 = overshoot |
| xfer_vld | input | 1 | Bus transfer valid strobe |
| start | input | 1 | Synchronous clear, opens a new window |
| scan_en | input | 1 | Serial shift mode |
| scan_in | input | 1 | Serial data into bit 0 |
| total | output | AW | Accumulated overshoot count |
| done | output | 1 | Window of WINDOW transfers complete |
| scan_out | output | 1 | MSB of total |

## Verification
The hardest situation to reach is the interaction between scan shifting and the window count. A shift taken while `xfer_vld` is high must neither add a count nor use up one of the window's transfers. The bench holds `xfer_vld` high throughout a short scan burst. It then counts exactly WINDOW further transfers and checks that `done` rises after the last one and not before. The full-overshoot window drives the register to its ceiling of WINDOW*LINES. That value is then shifted out, which exercises the MSB of the adder's range and the serial path in one sequence.

// File: rtl/ovs_tally.sv
module ovs_tally #(
  parameter int LINES  = 8,
  parameter int WINDOW = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [LINES-1:0]                      ind_n,
  input  logic                                  xfer_vld,
  input  logic                                  start,
  input  logic                                  scan_en,
  input  logic                                  scan_in,
  output logic [$clog2(WINDOW*LINES+1)-1:0]     total,
  output logic                                  done,
  output logic                                  scan_out
);
  localparam int CW  = $clog2(LINES+1);
  localparam int AW  = $clog2(WINDOW*LINES+1);
  localparam int WCW = $clog2(WINDOW+1);

  logic [CW-1:0]  zeros;
  logic [WCW-1:0] seen;
  logic           accept;

  always_comb begin
    zeros = '0;
    for (int i = 0; i < LINES; i++)
      zeros = zeros + CW'(!ind_n[i]);
  end

  assign accept   = xfer_vld && !done && !scan_en;
  assign scan_out = total[AW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total <= '0;
      seen  <= '0;
      done  <= 1'b0;
    end else if (start) begin
      total <= '0;
      seen  <= '0;
      done  <= 1'b0;
    end else if (scan_en) begin
      total <= {total[AW-2:0], scan_in};
    end else if (accept) begin
      total <= total + AW'(zeros);
      seen  <= seen + WCW'(1);
      if (seen == WCW'(WINDOW-1)) done <= 1'b1;
    end
  end

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (total == '0) && !done);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_vld && !start && !scan_en) |=> $stable(total) && $stable(done));

  // R5
  done_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start && !scan_en) |=> $stable(total) && done);

  // R7
  shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && !start) |=> (total[0] == $past(scan_in)) &&
                            (total[AW-1:1] == $past(total[AW-2:0])) &&
                            $stable(done));

  // R1
  reset_imm_chk: assert property (@(posedge clk)
    !rst_n |-> (total == '0) && !done);
endmodule

// File: tb/ovs_tally_tb.sv
module ovs_tally_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LINES  = 8;
  localparam int WINDOW = 4;
  localparam int AW = $clog2(WINDOW*LINES+1);
  localparam logic [7:0] PATS [8] = '{8'hFF, 8'hFE, 8'h00, 8'h5A,
                                     8'h7F, 8'h81, 8'hF0, 8'h3C};

  logic clk = 0, rst_n = 0, xfer_vld = 0, start = 0, scan_en = 0, scan_in = 0;
  logic [LINES-1:0] ind_n = '1;
  logic [AW-1:0] total;
  logic done, scan_out;
  int runs = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ovs_tally #(.LINES(LINES), .WINDOW(WINDOW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ind_n(ind_n), .xfer_vld(xfer_vld),
    .start(start), .scan_en(scan_en), .scan_in(scan_in),
    .total(total), .done(done), .scan_out(scan_out));

  function automatic int zcount(logic [7:0] p);
    int c = 0;
    for (int i = 0; i < 8; i++) if (p[i] == 1'b0) c++;
    return c;
  endfunction

  task automatic chk(string req, int act, int exp);
    runs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_start();
    start = 1; step(); start = 0;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    int acc;
    @(negedge clk);
    chk("R1 total", total, 0);
    chk("R1 done", done, 0);
    rst_n = 1; step();

    for (int w = 0; w < 2; w++) begin
      do_start();
      acc = 0;
      for (int k = 0; k < WINDOW; k++) begin
        ind_n = PATS[w*WINDOW+k]; xfer_vld = 1; step();
        acc += zcount(PATS[w*WINDOW+k]);
        chk("R2 total", total, acc);
        chk("R5 done", done, (k == WINDOW-1) ? 1 : 0);
        xfer_vld = 0; step();
        chk("R3 hold", total, acc);
      end
      ind_n = 8'h00; xfer_vld = 1; step(); xfer_vld = 0;
      chk("R5 frozen", total, acc);
      chk("R5 done stays", done, 1);
    end

    ind_n = 8'h00; xfer_vld = 1; start = 1; step(); start = 0; xfer_vld = 0;
    chk("R6 start priority", total, 0);
    chk("R6 done clear", done, 0);

    xfer_vld = 1; ind_n = 8'h00;
    for (int k = 0; k < WINDOW; k++) step();
    xfer_vld = 0;
    chk("R4 ceiling", total, WINDOW*LINES);
    chk("R4 done", done, 1);

    scan_en = 1; scan_in = 0;
    for (int b = AW-1; b >= 0; b--) begin
      chk("R8 scan_out", scan_out, ((WINDOW*LINES) >> b) & 1);
      scan_in = (6'b101101 >> b) & 1;
      step();
    end
    scan_en = 0;
    chk("R8 loaded", total, 6'b101101);
    chk("R7 done kept", done, 1);

    do_start();
    ind_n = 8'h00; xfer_vld = 1; scan_en = 1; scan_in = 0;
    step(); step();
    scan_en = 0;
    chk("R7 counts ignored", total, 0);
    ind_n = 8'hFE;
    for (int k = 0; k < WINDOW; k++) begin
      chk("R7 window not used", done, 0);
      step();
    end
    xfer_vld = 0;
    chk("R7 window total", total, WINDOW);
    chk("R5 done after window", done, 1);

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule